// File: doc/BRIEF.md
# ECC Read Fault Status Flags

This block holds two sticky status flags that record the outcome of flash array reads: one for a corrected single-bit fault and one for an uncorrectable double-bit fault. An ECC decoder, which sits outside this block, ends every read with a one-cycle completion strobe. The strobe carries a "corrected" or "uncorrectable" outcome. A command-busy input marks reads that collide with a flash command already running in the same block. A configuration input can suppress the reporting of single-bit faults.

Software reads the flags through a small two-register interface and clears them by writing ones. A second register holds one interrupt enable per flag. Each interrupt output is a registered AND of a flag and its enable. For a real ECC event the two flags never rise together. Both flags rise in the same cycle only when a read collides with a running command, and that pair is how a collision is reported.

Top module: `ecc_fault_flags`

## Requirements
- R1: After reset, both flags, both enables and both interrupt outputs are 0.
- R2: A completion strobe with the uncorrectable outcome and no busy command sets the double flag, which is bit 1 of the status register (register address 0).
- R3: A completion strobe with the corrected outcome, no uncorrectable outcome and no busy command sets the single flag (bit 0 of the status register) only while `ign_single` is 0. While `ign_single` is 1, the strobe leaves the single flag unchanged.
- R4: A strobe with no busy command never raises both flags in the same cycle. If both outcome inputs are high, only the double flag sets.
- R5: A strobe while `cmd_busy` is 1 sets both flags at once, whatever the outcome inputs and `ign_single` are.
- R6: A write to address 0 clears each flag whose data bit is 1 (bit 1 for the double flag, bit 0 for the single flag). A flag whose data bit is 0 keeps its value.
- R7: When a set event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R8: Outcome and busy inputs have no effect on the flags in any cycle without the completion strobe.
- R9: A write to address 1 loads the enables: bit 1 enables the double interrupt, bit 0 enables the single interrupt. Reading address 1 returns the enables in those bits. All upper bits of both registers read 0.
- R10: Each interrupt output equals its flag AND its enable as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_done | input | 1 | One-cycle read-completion strobe from the ECC decoder |
| rd_corr | input | 1 | Read outcome: a single-bit error was corrected |
| rd_uncorr | input | 1 | Read outcome: an uncorrectable error was found |
| cmd_busy | input | 1 | A flash command is running in the block being read |
| ign_single | input | 1 | Suppresses single-fault reporting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 selects status, 1 selects enables |
| wr_data | input | DW | Write data |
| rd_addr | input | 1 | Read address: 0 selects status, 1 selects enables |
| rd_data | output | DW | Read data, combinational |
| irq_dbl | output | 1 | Registered double-fault interrupt request |
| irq_sgl | output | 1 | Registered single-fault interrupt request |

## Verification
The assertions check the following properties on every cycle:
- a strobe sets the right flag;
- a collision sets both flags;
- a strobe with no busy command never raises both flags together;
- the flags hold in any cycle with no strobe and no write;
- each interrupt tracks the previous cycle's flag and enable.

Only the bench scenarios can show the effects that depend on register data values:
- selective write-one clearing, including a write of 0 that changes nothing;
- the set that wins over a clear in the same cycle;
- the readback of the enables with zero upper bits.

A reference model runs alongside random traffic and checks every cycle against these scenarios.

// File: rtl/ecc_fault_flags.sv
module ecc_fault_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_done,
  input  logic          rd_corr,
  input  logic          rd_uncorr,
  input  logic          cmd_busy,
  input  logic          ign_single,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq_dbl,
  output logic          irq_sgl
);
  localparam int PAD = DW - 2;

  logic       dbl_q, sgl_q;
  logic [1:0] en_q;
  logic       collide, set_dbl, set_sgl, wr_stat, wr_en_reg;
  logic       unused_wr_hi;

  assign collide   = rd_done & cmd_busy;
  assign set_dbl   = collide | (rd_done & rd_uncorr);
  assign set_sgl   = collide | (rd_done & ~rd_uncorr & rd_corr & ~ign_single);
  assign wr_stat   = wr_en & ~wr_addr;
  assign wr_en_reg = wr_en & wr_addr;
  assign unused_wr_hi = ^wr_data[DW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbl_q   <= 1'b0;
      sgl_q   <= 1'b0;
      en_q    <= 2'b00;
      irq_dbl <= 1'b0;
      irq_sgl <= 1'b0;
    end else begin
      dbl_q   <= set_dbl | (dbl_q & ~(wr_stat & wr_data[1]));
      sgl_q   <= set_sgl | (sgl_q & ~(wr_stat & wr_data[0]));
      if (wr_en_reg) en_q <= wr_data[1:0];
      irq_dbl <= dbl_q & en_q[1];
      irq_sgl <= sgl_q & en_q[0];
    end
  end

  assign rd_data = rd_addr ? {{PAD{1'b0}}, en_q} : {{PAD{1'b0}}, dbl_q, sgl_q};
endmodule

module ecc_fault_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_done,
  input logic       rd_corr,
  input logic       rd_uncorr,
  input logic       cmd_busy,
  input logic       ign_single,
  input logic       wr_en,
  input logic       dbl_q,
  input logic       sgl_q,
  input logic [1:0] en_q,
  input logic       irq_dbl,
  input logic       irq_sgl
);
  AST_DBL_SET: assert property (@(posedge clk) disable iff (!rst_n) rd_done && rd_uncorr |=> dbl_q); // R2
  AST_SGL_SET: assert property (@(posedge clk) disable iff (!rst_n) rd_done && rd_corr && !rd_uncorr && !ign_single |=> sgl_q); // R3
  AST_NO_PAIR: assert property (@(posedge clk) disable iff (!rst_n) rd_done && !cmd_busy |=> !($rose(dbl_q) && $rose(sgl_q))); // R4
  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n) rd_done && cmd_busy |=> dbl_q && sgl_q); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_done && !wr_en |=> $stable({dbl_q, sgl_q})); // R8
  AST_IRQ_D: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> irq_dbl == $past(dbl_q && en_q[1])); // R10
  AST_IRQ_S: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> irq_sgl == $past(sgl_q && en_q[0])); // R10
endmodule

bind ecc_fault_flags ecc_fault_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .rd_corr(rd_corr),
  .rd_uncorr(rd_uncorr), .cmd_busy(cmd_busy), .ign_single(ign_single),
  .wr_en(wr_en), .dbl_q(dbl_q), .sgl_q(sgl_q), .en_q(en_q),
  .irq_dbl(irq_dbl), .irq_sgl(irq_sgl)
);

// File: tb/sim_ecc_fault_flags.sv
module sim_ecc_fault_flags;
  localparam int DW = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_done = 0, rd_corr = 0, rd_uncorr = 0, cmd_busy = 0, ign_single = 0;
  logic wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic irq_dbl, irq_sgl;

  int total = 0, bad = 0;
  logic m_dbl = 0, m_sgl = 0, m_id = 0, m_is = 0;
  logic [1:0] m_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_fault_flags #(.DW(DW)) u0 (.*);

  function automatic logic next_flag(logic cur, logic setv, logic clr);
    return setv ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    rd_addr = 1'b0; #1;
    chk({req, " status"}, rd_data, {{(DW-2){1'b0}}, m_dbl, m_sgl});
    rd_addr = 1'b1; #1;
    chk({req, " enables"}, rd_data, {{(DW-2){1'b0}}, m_en});
    chk({req, " irq_dbl"}, {{(DW-1){1'b0}}, irq_dbl}, {{(DW-1){1'b0}}, m_id});
    chk({req, " irq_sgl"}, {{(DW-1){1'b0}}, irq_sgl}, {{(DW-1){1'b0}}, m_is});
  endtask

  task automatic cyc(logic d, logic c, logic u, logic b, logic ig,
                     logic we, logic wa, logic [DW-1:0] wd, string req);
    logic sd, ss, cd, cs;
    rd_done = d; rd_corr = c; rd_uncorr = u; cmd_busy = b; ign_single = ig;
    wr_en = we; wr_addr = wa; wr_data = wd;
    sd = d && (b || u);
    ss = d && (b || (!u && c && !ig));
    cd = we && !wa && wd[1];
    cs = we && !wa && wd[0];
    @(posedge clk);
    m_id = m_dbl && m_en[1];
    m_is = m_sgl && m_en[0];
    m_dbl = next_flag(m_dbl, sd, cd);
    m_sgl = next_flag(m_sgl, ss, cs);
    if (we && wa) m_en = wd[1:0];
    @(negedge clk);
    rd_done = 0; wr_en = 0;
    check_all(req);
  endtask

  task automatic idle(string req);
    cyc(0, 0, 0, 0, 0, 0, 0, '0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    // R9 enables write/readback
    cyc(0, 0, 0, 0, 0, 1, 1, 8'hFF, "R9 enable all");
    // R2 uncorrectable sets double
    cyc(1, 0, 1, 0, 0, 0, 0, '0, "R2 uncorrectable");
    idle("R10 irq follows");
    // R6 write 0 keeps, write 1 clears
    cyc(0, 0, 0, 0, 0, 1, 0, 8'h00, "R6 write zero");
    cyc(0, 0, 0, 0, 0, 1, 0, 8'h02, "R6 clear double");
    // R3 single with ignore set: no effect
    cyc(1, 1, 0, 0, 1, 0, 0, '0, "R3 ignored single");
    cyc(1, 1, 0, 0, 0, 0, 0, '0, "R3 single set");
    cyc(0, 0, 0, 0, 0, 1, 0, 8'h01, "R6 clear single");
    // R4 both outcomes, only double
    cyc(1, 1, 1, 0, 0, 0, 0, '0, "R4 priority");
    cyc(0, 0, 0, 0, 0, 1, 0, 8'hFF, "R6 clear all");
    // R8 outcomes without strobe ignored
    cyc(0, 1, 1, 1, 0, 0, 0, '0, "R8 no strobe");
    // R5 collision with ignore set
    cyc(1, 0, 0, 1, 1, 0, 0, '0, "R5 collision");
    // R7 set wins over clear
    cyc(1, 0, 0, 1, 0, 1, 0, 8'h03, "R7 set beats clear");
    cyc(0, 0, 0, 0, 0, 1, 1, 8'hFE, "R9 enable double only");
    idle("R10 single masked");

    for (int i = 0; i < 3000; i++) begin
      logic [DW-1:0] wd;
      wd = DW'($urandom);
      cyc(($urandom % 10) < 3, $urandom % 2, ($urandom % 4) == 0,
          ($urandom % 5) == 0, $urandom % 2, ($urandom % 4) == 0,
          $urandom % 2, wd, "R6 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule